// File: doc/BRIEF.md
# DMA Transmit Burst Request Scheduler

This block sits between a transmit descriptor fetch stage and a host memory read port. It takes one descriptor at a time, provided the descriptor's ownership bit is set. Each descriptor holds two data buffers and packet-boundary flags. The block cuts the buffers into read bursts, each no longer than a programmable burst length. For each burst it places a request carrying the start address, the byte count and start/end-of-packet markers.

Before each request goes out, the block checks that the transmit queue has room for the burst. The queue-free figure it uses is reduced by the bytes still in flight. At most two requests may be outstanding at a time. Their completions return in issue order through a small tag FIFO. When the completion for a descriptor's final burst arrives, the block pulses a write-back output so the descriptor can be closed.

The walker frees itself for the next descriptor as soon as the final burst of the current one is accepted. Short packets can therefore be requested back to back while earlier data is still being fetched. Buffer 1 length must be nonzero.

Top module: `txdma_burst_sched`

## Requirements
- R1: A descriptor offered with `desc_own` = 0 is not taken. `desc_ready` stays high, and no request is produced from it.
- R2: Every request length is nonzero and equals the smaller of `cfg_burst_len` and the bytes left in the current buffer.
- R3: A request is presented only while `q_free` ≥ (bytes of outstanding requests + its own length). Equality is enough. Otherwise it stalls until space appears.
- R4: Requests walk in a fixed order: the rest of the current buffer at an address advanced by the bytes already requested, then buffer 2 of the same descriptor, then buffer 1 of the next descriptor.
- R5: A buffer 2 length of zero produces no request. The descriptor ends with its last buffer 1 burst.
- R6: No more than two requests are outstanding. A third waits until a completion arrives.
- R7: Each `cpl_valid` cycle retires the oldest outstanding request. This frees one slot and its bytes of queue space for the following cycle.
- R8: `wb_valid` is high exactly in the cycle in which the completion for a descriptor's final request arrives. In that cycle `wb_eop` equals that descriptor's last-segment flag.
- R9: `req_sop` is 1 only on the first request of a descriptor with `desc_first` = 1. `req_eop` is 1 only on the final request of a descriptor with `desc_last` = 1.
- R10: `desc_ready` rises the cycle after the final request of a descriptor is accepted, without waiting for completions. A short following packet is therefore requested while the previous one is still outstanding.
- R11: While `req_valid` is high and `req_ready` low, `req_addr`, `req_len` and the flags hold their values.
- R12: After reset, `req_valid` = 0, `wb_valid` = 0 and `desc_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | LEN_W | Largest burst in bytes (nonzero) |
| desc_valid | input | 1 | Descriptor offered |
| desc_own | input | 1 | Ownership bit; 1 means the descriptor may be used |
| desc_ready | output | 1 | Walker idle and able to take a descriptor |
| desc_b1_addr | input | ADDR_W | Buffer 1 start address |
| desc_b1_len | input | LEN_W | Buffer 1 length in bytes (nonzero) |
| desc_b2_addr | input | ADDR_W | Buffer 2 start address |
| desc_b2_len | input | LEN_W | Buffer 2 length in bytes, 0 if unused |
| desc_first | input | 1 | Descriptor opens a packet |
| desc_last | input | 1 | Descriptor closes a packet |
| q_free | input | QS_W | Free bytes in the transmit queue |
| req_valid | output | 1 | Read burst request present |
| req_ready | input | 1 | Host interface accepts the request |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | LEN_W | Burst length in bytes |
| req_sop | output | 1 | Burst starts a packet |
| req_eop | output | 1 | Burst ends a packet |
| cpl_valid | input | 1 | Oldest request's data has been written into the queue |
| wb_valid | output | 1 | Descriptor finished, hand to write-back |
| wb_eop | output | 1 | Finished descriptor closed a packet |

## Verification
A table of single descriptors drives the splitter with several combinations. These cover buffers that are exact multiples of the burst, buffers with a short tail, a one-byte buffer, an empty second buffer and a burst length larger than both buffers. Together they separate a wrong length cap from a wrong address step or a missed buffer-2 skip. Directed patterns then cover a few stall cases. Completions are withheld to expose the two-request limit. The queue space is set just below and then exactly at the needed amount, which pins the comparison boundary. Two short descriptors forming one packet are chained back to back, which separates early descriptor release from waiting for data, and shows completion order through the write-back flags.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  // Walker position inside the current descriptor
  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_BUF1 = 2'd1,
    W_BUF2 = 2'd2
  } walk_e;

  // Per-request bookkeeping carried alongside the byte count
  typedef struct packed {
    logic desc_end;  // final request of its descriptor
    logic eop;       // final request of a packet
  } tag_flags_t;

endpackage

// File: rtl/txdma_tag_fifo.sv
module txdma_tag_fifo
  import txdma_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int LEN_W = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SUM_W = LEN_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  tag_flags_t       push_flags,
  input  logic             pop,
  output logic [LEN_W-1:0] head_len,
  output tag_flags_t       head_flags,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count,
  output logic [SUM_W-1:0] pend_bytes
);

  logic [LEN_W-1:0] len_q [DEPTH];
  tag_flags_t       flg_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum_q, sum_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_d = push ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q + CNT_W'(push) - CNT_W'(pop);
    sum_d    = sum_q;
    if (push) sum_d = sum_d + SUM_W'(push_len);
    if (pop)  sum_d = sum_d - SUM_W'(len_q[rd_ptr_q]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      sum_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      sum_q    <= sum_d;
    end
  end

  // Entry storage, one write enable per slot
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        len_q[i] <= '0;
        flg_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push && (wr_ptr_q == PTR_W'(i))) begin
          len_q[i] <= push_len;
          flg_q[i] <= push_flags;
        end
      end
    end
  end

  assign head_len   = len_q[rd_ptr_q];
  assign head_flags = flg_q[rd_ptr_q];
  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign empty      = (cnt_q == '0);
  assign count      = cnt_q;
  assign pend_bytes = sum_q;

endmodule

// File: rtl/txdma_burst_calc.sv
module txdma_burst_calc #(
  parameter int LEN_W = 16,
  parameter int QS_W  = 16,
  parameter int PB_W  = 18,
  localparam int CMP_W = ((QS_W > PB_W) ? QS_W : PB_W) + 1
) (
  input  logic [LEN_W-1:0] burst_len,
  input  logic [LEN_W-1:0] rem_len,
  input  logic [QS_W-1:0]  q_free,
  input  logic [PB_W-1:0]  pend_bytes,
  output logic [LEN_W-1:0] chunk_len,
  output logic             chunk_tail,
  output logic             room_ok
);

  logic [CMP_W-1:0] need;

  always_comb begin
    chunk_tail = (rem_len <= burst_len);
    chunk_len  = chunk_tail ? rem_len : burst_len;
    need       = CMP_W'(pend_bytes) + CMP_W'(chunk_len);
    room_ok    = (CMP_W'(q_free) >= need);
  end

endmodule

// File: rtl/txdma_burst_sched.sv
module txdma_burst_sched
  import txdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int QS_W    = 16,
  parameter int MAX_OUT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_burst_len,
  input  logic              desc_valid,
  input  logic              desc_own,
  output logic              desc_ready,
  input  logic [ADDR_W-1:0] desc_b1_addr,
  input  logic [LEN_W-1:0]  desc_b1_len,
  input  logic [ADDR_W-1:0] desc_b2_addr,
  input  logic [LEN_W-1:0]  desc_b2_len,
  input  logic              desc_first,
  input  logic              desc_last,
  input  logic [QS_W-1:0]   q_free,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic              req_sop,
  output logic              req_eop,
  input  logic              cpl_valid,
  output logic              wb_valid,
  output logic              wb_eop
);

  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam int PB_W  = LEN_W + CNT_W;

  walk_e             state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d, b2_addr_q, b2_addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d, b2_len_q, b2_len_d;
  logic              sop_q, sop_d, last_q, last_d;

  logic              desc_take, req_fire, desc_done;
  logic [LEN_W-1:0]  chunk_len;
  logic              chunk_tail, room_ok;
  logic              fifo_full, fifo_empty, fifo_pop;
  logic [LEN_W-1:0]  head_len;
  tag_flags_t        head_flags, push_flags;
  logic [CNT_W-1:0]  out_cnt;
  logic [PB_W-1:0]   pend_bytes;

  // Burst sizing and queue space check
  txdma_burst_calc #(
    .LEN_W (LEN_W),
    .QS_W  (QS_W),
    .PB_W  (PB_W)
  ) u_calc (
    .burst_len  (cfg_burst_len),
    .rem_len    (rem_q),
    .q_free     (q_free),
    .pend_bytes (pend_bytes),
    .chunk_len  (chunk_len),
    .chunk_tail (chunk_tail),
    .room_ok    (room_ok)
  );

  // In-order tracker of outstanding requests
  txdma_tag_fifo #(
    .DEPTH (MAX_OUT),
    .LEN_W (LEN_W)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (req_fire),
    .push_len   (chunk_len),
    .push_flags (push_flags),
    .pop        (fifo_pop),
    .head_len   (head_len),
    .head_flags (head_flags),
    .full       (fifo_full),
    .empty      (fifo_empty),
    .count      (out_cnt),
    .pend_bytes (pend_bytes)
  );

  // Handshakes and request decode
  always_comb begin
    desc_ready = (state_q == W_IDLE);
    desc_take  = desc_valid && desc_own && desc_ready;
    req_valid  = (state_q != W_IDLE) && !fifo_full && room_ok;
    req_fire   = req_valid && req_ready;
    desc_done  = chunk_tail && ((state_q == W_BUF2) || (b2_len_q == '0));
    req_addr   = addr_q;
    req_len    = chunk_len;
    req_sop    = sop_q;
    req_eop    = desc_done && last_q;
    push_flags.desc_end = desc_done;
    push_flags.eop      = req_eop;
    fifo_pop   = cpl_valid && !fifo_empty;
    wb_valid   = fifo_pop && head_flags.desc_end;
    wb_eop     = head_flags.eop;
  end

  // Walker next state
  always_comb begin
    state_d   = state_q;
    addr_d    = addr_q;
    rem_d     = rem_q;
    b2_addr_d = b2_addr_q;
    b2_len_d  = b2_len_q;
    sop_d     = sop_q;
    last_d    = last_q;
    if (desc_take) begin
      state_d   = W_BUF1;
      addr_d    = desc_b1_addr;
      rem_d     = desc_b1_len;
      b2_addr_d = desc_b2_addr;
      b2_len_d  = desc_b2_len;
      sop_d     = desc_first;
      last_d    = desc_last;
    end else if (req_fire) begin
      sop_d = 1'b0;
      if (!chunk_tail) begin
        addr_d = addr_q + ADDR_W'(chunk_len);
        rem_d  = rem_q - chunk_len;
      end else if (!desc_done) begin
        state_d = W_BUF2;
        addr_d  = b2_addr_q;
        rem_d   = b2_len_q;
      end else begin
        state_d = W_IDLE;
        rem_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= W_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      b2_addr_q <= '0;
      b2_len_q  <= '0;
      sop_q     <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      addr_q    <= addr_d;
      rem_q     <= rem_d;
      b2_addr_q <= b2_addr_d;
      b2_len_q  <= b2_len_d;
      sop_q     <= sop_d;
      last_q    <= last_d;
    end
  end

endmodule

// File: rtl/txdma_burst_sched_chk.sv
module txdma_burst_sched_chk #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 2,
  parameter int MAX_OUT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LEN_W-1:0]  cfg_burst_len,
  input logic              desc_valid,
  input logic              desc_own,
  input logic              desc_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_eop,
  input logic              cpl_valid,
  input logic              wb_valid,
  input logic [CNT_W-1:0]  out_cnt
);

  // R1: an unowned offer leaves the walker free
  p_own_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_own && desc_ready) |=> desc_ready);

  // R2: burst size bounded and nonzero
  p_len_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0 && req_len <= cfg_burst_len));

  // R6: outstanding count never above the limit
  p_max_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= CNT_W'(MAX_OUT));

  // R8: write-back only alongside a completion
  p_wb_cpl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> cpl_valid);

  // R10: walker free right after a packet's final burst is taken
  p_ready_after_final_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_eop) |=> desc_ready);

  // R11: stalled request holds address and end flag
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> ($stable(req_addr) && $stable(req_eop)));

endmodule

bind txdma_burst_sched txdma_burst_sched_chk #(
  .ADDR_W  (ADDR_W),
  .LEN_W   (LEN_W),
  .CNT_W   (CNT_W),
  .MAX_OUT (MAX_OUT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_burst_len (cfg_burst_len),
  .desc_valid    (desc_valid),
  .desc_own      (desc_own),
  .desc_ready    (desc_ready),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .req_len       (req_len),
  .req_eop       (req_eop),
  .cpl_valid     (cpl_valid),
  .wb_valid      (wb_valid),
  .out_cnt       (out_cnt)
);

// File: tb/txdma_burst_sched_tb.sv
module txdma_burst_sched_tb;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int QS_W   = 16;
  localparam int NV     = 6;

  // Table: burst length, buffer 1 length, buffer 2 length, first, last, expected request count
  localparam int VB [NV] = '{64, 64, 32, 256, 16, 128};
  localparam int V1 [NV] = '{200, 64, 10, 100, 16, 1};
  localparam int V2 [NV] = '{0, 64, 50, 30, 0, 129};
  localparam int VF [NV] = '{1, 1, 1, 0, 1, 1};
  localparam int VL [NV] = '{1, 1, 0, 1, 1, 1};
  localparam int VN [NV] = '{4, 2, 3, 2, 1, 3};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic [LEN_W-1:0]  cfg_burst_len;
  logic              desc_valid, desc_own, desc_ready;
  logic [ADDR_W-1:0] desc_b1_addr, desc_b2_addr;
  logic [LEN_W-1:0]  desc_b1_len, desc_b2_len;
  logic              desc_first, desc_last;
  logic [QS_W-1:0]   q_free;
  logic              req_valid, req_ready, req_sop, req_eop;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic              cpl_valid, wb_valid, wb_eop;

  txdma_burst_sched #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .QS_W   (QS_W)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_burst_len (cfg_burst_len),
    .desc_valid    (desc_valid),
    .desc_own      (desc_own),
    .desc_ready    (desc_ready),
    .desc_b1_addr  (desc_b1_addr),
    .desc_b1_len   (desc_b1_len),
    .desc_b2_addr  (desc_b2_addr),
    .desc_b2_len   (desc_b2_len),
    .desc_first    (desc_first),
    .desc_last     (desc_last),
    .q_free        (q_free),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_len       (req_len),
    .req_sop       (req_sop),
    .req_eop       (req_eop),
    .cpl_valid     (cpl_valid),
    .wb_valid      (wb_valid),
    .wb_eop        (wb_eop)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Expected request stream and expected write-back flags
  longint e_addr [256];
  int     e_len  [256];
  bit     e_sop  [256];
  bit     e_eop  [256];
  int     e_wr = 0, e_rd = 0;
  bit     w_eop  [64];
  int     w_wr = 0, w_rd = 0;
  int     outstanding = 0;
  bit     cpl_auto = 1'b1;
  bit     desc_took = 1'b0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference walk of one descriptor
  task automatic plan_desc(input longint a1, input int l1, input longint a2, input int l2,
                           input int bl, input bit f, input bit l);
    bit first = 1'b1;
    for (int b = 0; b < 2; b++) begin
      longint a = (b == 0) ? a1 : a2;
      int     r = (b == 0) ? l1 : l2;
      while (r > 0) begin
        int c = (r > bl) ? bl : r;
        e_addr[e_wr] = a;
        e_len[e_wr]  = c;
        e_sop[e_wr]  = first && f;
        first = 1'b0;
        r = r - c;
        a = a + c;
        e_eop[e_wr]  = (r == 0) && ((b == 1) || (l2 == 0)) && l;
        e_wr++;
      end
    end
    w_eop[w_wr] = l;
    w_wr++;
  endtask

  // One clock: sample before the edge, advance to the next falling edge
  task automatic tick();
    bit rf, df, cf;
    #1;
    rf = req_valid && req_ready;
    df = desc_valid && desc_own && desc_ready;
    cf = cpl_valid;
    if (rf) begin
      check("R6 slot free at issue", (outstanding < 2), 1);
      if (e_rd >= e_wr) begin
        check("R4 unexpected request", 1, 0);
      end else begin
        check("R4 address", req_addr, e_addr[e_rd]);
        check("R2 length", req_len, e_len[e_rd]);
        check("R9 sop", req_sop, e_sop[e_rd]);
        check("R9 eop", req_eop, e_eop[e_rd]);
        e_rd++;
      end
    end
    if (wb_valid) begin
      if (w_rd >= w_wr) check("R8 unexpected write-back", 1, 0);
      else begin
        check("R8 R7 write-back eop in order", wb_eop, w_eop[w_rd]);
        w_rd++;
      end
    end
    if (df) desc_took = 1'b1;
    @(posedge clk);
    if (rf) outstanding++;
    if (cf && outstanding > 0) outstanding--;
    @(negedge clk);
    if (cpl_auto) cpl_valid = (outstanding > 0);
  endtask

  task automatic give_desc(input longint a1, input int l1, input longint a2, input int l2,
                           input bit f, input bit l);
    plan_desc(a1, l1, a2, l2, int'(cfg_burst_len), f, l);
    desc_b1_addr = ADDR_W'(a1);
    desc_b1_len  = LEN_W'(l1);
    desc_b2_addr = ADDR_W'(a2);
    desc_b2_len  = LEN_W'(l2);
    desc_first   = f;
    desc_last    = l;
    desc_own     = 1'b1;
    desc_valid   = 1'b1;
    desc_took    = 1'b0;
    for (int k = 0; k < 60 && !desc_took; k++) tick();
    desc_valid = 1'b0;
    check("R10 descriptor taken", desc_took, 1);
  endtask

  task automatic drain();
    for (int k = 0; k < 500 && !(e_rd == e_wr && outstanding == 0); k++) tick();
    tick();
    check("R4 all requests seen", e_rd, e_wr);
    check("R8 all write-backs seen", w_rd, w_wr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int start;
    bit saw;
    rst_n = 1'b0;
    cfg_burst_len = LEN_W'(64);
    desc_valid = 1'b0; desc_own = 1'b0;
    desc_b1_addr = '0; desc_b1_len = '0; desc_b2_addr = '0; desc_b2_len = '0;
    desc_first = 1'b0; desc_last = 1'b0;
    q_free = QS_W'(4096);
    req_ready = 1'b1;
    cpl_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R12: reset values
    check("R12 req_valid", req_valid, 0);
    check("R12 wb_valid", wb_valid, 0);
    check("R12 desc_ready", desc_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: one descriptor at a time, completions returned promptly
    for (int i = 0; i < NV; i++) begin
      cfg_burst_len = LEN_W'(VB[i]);
      start = e_wr;
      give_desc(longint'(32'h1000 * (i + 1)), V1[i], longint'(32'h1000 * (i + 1) + 32'h800),
                V2[i], VF[i][0], VL[i][0]);
      drain();
      check("R2 R5 request count", e_wr - start, VN[i]);
    end

    // R1: unowned descriptor is ignored
    cfg_burst_len = LEN_W'(64);
    desc_b1_addr = 32'h9000; desc_b1_len = 16'd40; desc_b2_len = '0;
    desc_first = 1'b1; desc_last = 1'b1;
    desc_own = 1'b0; desc_valid = 1'b1; desc_took = 1'b0;
    saw = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      if (req_valid) saw = 1'b1;
      tick();
    end
    desc_valid = 1'b0;
    check("R1 no request from unowned", saw, 0);
    check("R1 not taken", desc_took, 0);
    check("R1 ready kept", desc_ready, 1);
    give_desc(64'h9000, 40, 64'h0, 0, 1'b1, 1'b1);
    drain();

    // R11 / R6 / R7: stall on ready, then on the outstanding limit
    cpl_auto = 1'b0; cpl_valid = 1'b0;
    cfg_burst_len = LEN_W'(32);
    req_ready = 1'b0;
    start = e_rd;
    give_desc(64'hA000, 128, 64'h0, 0, 1'b1, 1'b1);
    for (int k = 0; k < 3; k++) begin
      tick();
      #1;
      check("R11 held valid", req_valid, 1);
      check("R11 held addr", req_addr, 64'hA000);
      check("R11 held len", req_len, 32);
    end
    req_ready = 1'b1;
    for (int k = 0; k < 5; k++) tick();
    #1;
    check("R6 two issued then stall", e_rd - start, 2);
    check("R6 no third request", req_valid, 0);
    cpl_valid = 1'b1;
    req_ready = 1'b0;
    tick();
    cpl_valid = 1'b0;
    #1;
    check("R7 completion frees a slot", req_valid, 1);
    check("R7 one retired", outstanding, 1);
    req_ready = 1'b1;
    cpl_auto = 1'b1;
    drain();

    // R3: queue space gate, exact boundary
    cpl_auto = 1'b0; cpl_valid = 1'b0;
    q_free = QS_W'(40);
    start = e_rd;
    give_desc(64'hB000, 64, 64'h0, 0, 1'b1, 1'b1);
    for (int k = 0; k < 5; k++) tick();
    #1;
    check("R3 first fits, second stalls", e_rd - start, 1);
    check("R3 stalled valid", req_valid, 0);
    q_free = QS_W'(64);
    tick();
    check("R3 exact room issues", e_rd - start, 2);
    q_free = QS_W'(4096);
    cpl_auto = 1'b1;
    drain();

    // R10 / R7 / R8: two short descriptors of one packet, no completions yet
    cpl_auto = 1'b0; cpl_valid = 1'b0;
    cfg_burst_len = LEN_W'(64);
    start = e_rd;
    give_desc(64'hC000, 20, 64'h0, 0, 1'b1, 1'b0);
    give_desc(64'hD000, 24, 64'h0, 0, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) tick();
    check("R10 both requested before data", e_rd - start, 2);
    check("R10 two outstanding", outstanding, 2);
    check("R8 no write-back without completion", w_rd, w_wr - 2);
    cpl_auto = 1'b1;
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule